// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block is the receive side of an I2C target. A bit-level front end hands it three kinds of bus event: a start carrying the 7-bit address and direction bit, a stream of received data bytes, and a stop. When target matching is enabled and a write start carries the programmed own address, the block acknowledges the address phase and opens a receive session. While the session is open, each received byte goes straight to memory through a byte-wide write port. The write lands at a buffer pointer that then moves up by one, while a remaining-length register counts down and a received-byte counter counts up.

A stop that ends an open session raises four interrupt status bits at once and asserts the interrupt line. Software reads the status, clears it by writing ones, and reprograms the pointer and length for the next packet. The register port is a simple single-cycle write strobe with a combinational read mux. The data byte stream and the memory write port are valid/ready channels. The block takes a byte only when `rx_ready` is high, and `rx_ready` stays low while a memory write is pending. Once `mem_valid` rises, it stays high with address and data held until `mem_ready` is seen.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `mem_valid` and `rx_resp_valid` are low, and `rx_ready` is high.
- R2: Register offsets are: function control 0x00, interrupt enable 0x20, interrupt status 0x24, command 0x28, DMA length 0x2C, transmit buffer 0x30, receive buffer 0x34, own address 0x38 (bits 6:0), transfer counts 0x3C, operating address 0x40, operating length 0x44. Function control keeps only bits 22:0 and its bit 1 is the target-enable bit. Interrupt enable and command read back what was written.
- R3: A start with `ev_rnw`=0, `ev_addr` equal to the own address and target enable set raises `addr_ack` for one cycle, the cycle after the start, and zeroes the received count. Any other start gives no `addr_ack`.
- R4: A byte accepted in an open session with nonzero length raises `mem_valid` the next cycle, with `mem_addr` equal to the pointer and `mem_data` equal to the byte. The cycle after the `mem_valid`/`mem_ready` handshake, `rx_resp_valid` pulses with `rx_resp_ack`=1. The pointer has then gone up by one, the length down by one and the received count up by one.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold and `rx_ready` is low. No write happens until `mem_ready` is seen.
- R6: A byte accepted when the length is zero, or outside an open session, is not written. `rx_resp_valid` pulses with `rx_resp_ack`=0 in the next cycle, and the pointer, length and count are unchanged.
- R7: A stop during an open session sets status bits 16 (packet done), 7 (address match), 4 (stop seen) and 2 (receive done). The status reads 0x00010094 and `irq` is high from the next cycle.
- R8: Writing the status register clears each bit written as one. When bit 16 of the written value is one, the clear mask is first OR-ed with 0x000280B5.
- R9: After a status clear leaves the whole status at zero, `irq` goes low the next cycle. If any bit is still set, `irq` stays high.
- R10: The transfer-count register reads the transmit count in bits 15:0 (always zero here) and the received count in bits 31:16. Any write to it clears both.
- R11: A write to either buffer offset loads the one shared pointer, and both offsets read that pointer. The operating address and operating length read the live pointer and the remaining length, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_start | input | 1 | Start event with address, one cycle |
| ev_addr | input | 7 | Address carried by the start |
| ev_rnw | input | 1 | Direction bit, 1 = read from target |
| ev_stop | input | 1 | Stop event, one cycle |
| addr_ack | output | 1 | Address phase acknowledge pulse |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| rx_resp_valid | output | 1 | Byte response pulse |
| rx_resp_ack | output | 1 | 1 = ACK, 0 = NACK, valid with rx_resp_valid |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Interrupt line |

## Verification
Every result in this block appears exactly one clock edge after its cause. A register write becomes visible on the read mux after the edge that takes it. `addr_ack` is high in the cycle after the start. `mem_valid` rises in the cycle after the byte handshake, and the ACK or NACK response lands one cycle after the memory handshake or the refused byte. Status and `irq` change one cycle after a stop or a clear. The bench drives every stimulus for one edge. It samples 1 ns after that edge to check each of these, and re-samples across several stalled cycles to show the memory request holds under back-pressure.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_FUNC   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IEN    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_ISTS   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_CMD    = 8'h28;
  localparam logic [REG_AW-1:0] OFS_LEN    = 8'h2c;
  localparam logic [REG_AW-1:0] OFS_TXBUF  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_RXBUF  = 8'h34;
  localparam logic [REG_AW-1:0] OFS_OWN    = 8'h38;
  localparam logic [REG_AW-1:0] OFS_CNT    = 8'h3c;
  localparam logic [REG_AW-1:0] OFS_OPADDR = 8'h40;
  localparam logic [REG_AW-1:0] OFS_OPLEN  = 8'h44;

  localparam int FUNC_KEEP_W = 23;
  localparam int FUNC_EN_BIT = 1;

  localparam int ST_PKT   = 16;
  localparam int ST_MATCH = 7;
  localparam int ST_STOP  = 4;
  localparam int ST_RXD   = 2;
  localparam logic [31:0] PKT_CLR_EXTRA = 32'h0002_80b5;

  typedef enum logic [0:0] {MV_IDLE, MV_WRITE} mv_state_t;
endpackage

// File: rtl/tgt_addr_match.sv
module tgt_addr_match #(
  parameter int TA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [TA_W-1:0] own_addr,
  input  logic            ev_start,
  input  logic [TA_W-1:0] ev_addr,
  input  logic            ev_rnw,
  input  logic            ev_stop,
  output logic            start_hit,
  output logic            stop_hit,
  output logic            session,
  output logic            addr_ack
);
  assign start_hit = ev_start && enable && !ev_rnw && (ev_addr == own_addr);
  assign stop_hit  = ev_stop && session;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session  <= 1'b0;
      addr_ack <= 1'b0;
    end else begin
      addr_ack <= start_hit;
      if (ev_start)     session <= start_hit;
      else if (ev_stop) session <= 1'b0;
    end
  end
endmodule

// File: rtl/tgt_rx_mover.sv
module tgt_rx_mover
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             session,
  input  logic             cnt_clr,
  input  logic             ptr_ld,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             len_ld,
  input  logic [LEN_W-1:0] len_val,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             mem_valid,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_data,
  input  logic             mem_ready,
  output logic             resp_valid,
  output logic             resp_ack,
  output logic [PTR_W-1:0] ptr,
  output logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] rx_cnt
);
  mv_state_t  state;
  logic [7:0] byte_q;
  logic       take, refuse, write_done;

  assign rx_ready   = (state == MV_IDLE);
  assign take       = rx_valid && rx_ready;
  assign refuse     = take && (!session || (len == '0));
  assign mem_valid  = (state == MV_WRITE);
  assign write_done = mem_valid && mem_ready;
  assign mem_addr   = ptr;
  assign mem_data   = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= MV_IDLE;
      byte_q     <= '0;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      resp_valid <= refuse || write_done;
      resp_ack   <= write_done;
      case (state)
        MV_IDLE: begin
          if (take && !refuse) begin
            byte_q <= rx_data;
            state  <= MV_WRITE;
          end
        end
        default: begin
          if (mem_ready) state <= MV_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      len    <= '0;
      rx_cnt <= '0;
    end else begin
      if (ptr_ld)          ptr <= ptr_val;
      else if (write_done) ptr <= ptr + PTR_W'(1);
      if (len_ld)          len <= len_val;
      else if (write_done) len <= len - LEN_W'(1);
      if (cnt_clr)         rx_cnt <= '0;
      else if (write_done) rx_cnt <= rx_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tgt_irq_status.sv
module tgt_irq_status
  import i2c_tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_done,
  input  logic        clr_we,
  input  logic [31:0] clr_val,
  output logic [31:0] status,
  output logic        irq
);
  logic [31:0] clr_mask, set_mask, status_nx;

  always_comb begin
    clr_mask = '0;
    if (clr_we) begin
      clr_mask = clr_val;
      if (clr_val[ST_PKT]) clr_mask = clr_val | PKT_CLR_EXTRA;
    end
    set_mask = '0;
    if (set_done) begin
      set_mask[ST_PKT]   = 1'b1;
      set_mask[ST_MATCH] = 1'b1;
      set_mask[ST_STOP]  = 1'b1;
      set_mask[ST_RXD]   = 1'b1;
    end
    status_nx = (status & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      if (set_done)                      irq <= 1'b1;
      else if (clr_we && status_nx == '0) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma
  import i2c_tgt_pkg::*;
#(
  parameter int TA_W  = 7,
  parameter int PTR_W = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_start,
  input  logic [TA_W-1:0]  ev_addr,
  input  logic             ev_rnw,
  input  logic             ev_stop,
  output logic             addr_ack,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             rx_resp_valid,
  output logic             rx_resp_ack,
  output logic             mem_valid,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_data,
  input  logic             mem_ready,
  output logic             irq
);
  logic [FUNC_KEEP_W-1:0] func_q;
  logic [31:0]            ien_q, cmd_q;
  logic [TA_W-1:0]        own_q;
  logic                   start_hit, stop_hit, session;
  logic                   ptr_ld, len_ld, cnt_clr, sts_we;
  logic [PTR_W-1:0]       ptr;
  logic [LEN_W-1:0]       len;
  logic [CNT_W-1:0]       rx_cnt;
  logic [31:0]            status;

  assign ptr_ld  = reg_wr && (reg_addr == OFS_TXBUF || reg_addr == OFS_RXBUF);
  assign len_ld  = reg_wr && (reg_addr == OFS_LEN);
  assign sts_we  = reg_wr && (reg_addr == OFS_ISTS);
  assign cnt_clr = start_hit || (reg_wr && reg_addr == OFS_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      ien_q  <= '0;
      cmd_q  <= '0;
      own_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_FUNC: func_q <= reg_wdata[FUNC_KEEP_W-1:0];
        OFS_IEN:  ien_q  <= reg_wdata;
        OFS_CMD:  cmd_q  <= reg_wdata;
        OFS_OWN:  own_q  <= reg_wdata[TA_W-1:0];
        default:  ;
      endcase
    end
  end

  tgt_addr_match #(.TA_W(TA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (func_q[FUNC_EN_BIT]),
    .own_addr  (own_q),
    .ev_start  (ev_start),
    .ev_addr   (ev_addr),
    .ev_rnw    (ev_rnw),
    .ev_stop   (ev_stop),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .session   (session),
    .addr_ack  (addr_ack)
  );

  tgt_rx_mover #(.PTR_W(PTR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .session    (session),
    .cnt_clr    (cnt_clr),
    .ptr_ld     (ptr_ld),
    .ptr_val    (reg_wdata[PTR_W-1:0]),
    .len_ld     (len_ld),
    .len_val    (reg_wdata[LEN_W-1:0]),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_ready  (mem_ready),
    .resp_valid (rx_resp_valid),
    .resp_ack   (rx_resp_ack),
    .ptr        (ptr),
    .len        (len),
    .rx_cnt     (rx_cnt)
  );

  tgt_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (stop_hit),
    .clr_we   (sts_we),
    .clr_val  (reg_wdata),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_FUNC:   reg_rdata = 32'(func_q);
      OFS_IEN:    reg_rdata = ien_q;
      OFS_ISTS:   reg_rdata = status;
      OFS_CMD:    reg_rdata = cmd_q;
      OFS_LEN:    reg_rdata = 32'(len);
      OFS_TXBUF:  reg_rdata = 32'(ptr);
      OFS_RXBUF:  reg_rdata = 32'(ptr);
      OFS_OWN:    reg_rdata = 32'(own_q);
      OFS_CNT:    reg_rdata = 32'(rx_cnt) << 16;
      OFS_OPADDR: reg_rdata = 32'(ptr);
      OFS_OPLEN:  reg_rdata = 32'(len);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tgt_rx_dma_chk.sv
module tgt_rx_dma_chk #(
  parameter int TA_W  = 7,
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_start,
  input logic [TA_W-1:0]  ev_addr,
  input logic             ev_rnw,
  input logic [TA_W-1:0]  own_q,
  input logic             en,
  input logic             addr_ack,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [PTR_W-1:0] mem_addr,
  input logic [7:0]       mem_data,
  input logic             rx_ready,
  input logic             rx_resp_valid,
  input logic             rx_resp_ack,
  input logic             stop_hit,
  input logic [31:0]      status,
  input logic             irq
);
  // R3
  ack_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> $past(ev_start && !ev_rnw && en && (ev_addr == own_q)));
  // R4
  ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_resp_valid && rx_resp_ack) |-> $past(mem_valid && mem_ready));
  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !rx_ready);
  // R6
  nack_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_resp_valid && !rx_resp_ack) |-> !$past(mem_valid));
  // R7
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (irq && status[16] && status[7] && status[4] && status[2]));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == 32'h0));
endmodule

bind i2c_tgt_rx_dma tgt_rx_dma_chk #(.TA_W(TA_W), .PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_start      (ev_start),
  .ev_addr       (ev_addr),
  .ev_rnw        (ev_rnw),
  .own_q         (own_q),
  .en            (func_q[1]),
  .addr_ack      (addr_ack),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_data      (mem_data),
  .rx_ready      (rx_ready),
  .rx_resp_valid (rx_resp_valid),
  .rx_resp_ack   (rx_resp_ack),
  .stop_hit      (stop_hit),
  .status        (status),
  .irq           (irq)
);

// File: tb/test_i2c_tgt_rx_dma.sv
`timescale 1ns/1ps
module test_i2c_tgt_rx_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_start = 1'b0;
  logic [6:0]  ev_addr = '0;
  logic        ev_rnw = 1'b0;
  logic        ev_stop = 1'b0;
  logic        addr_ack;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        rx_resp_valid, rx_resp_ack;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [7:0] mem_img [0:63];

  always #10 clk = ~clk;

  i2c_tgt_rx_dma i_i2c_tgt_rx_dma (.*);

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      mem_img[mem_addr[5:0]] <= mem_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(a, v);
    chk(tag, v, exp);
  endtask

  task automatic start_ev(input string tag, input logic [6:0] a, input logic rnw, input logic exp);
    @(negedge clk);
    ev_start = 1'b1; ev_addr = a; ev_rnw = rnw;
    @(posedge clk); #1;
    ev_start = 1'b0;
    chk(tag, 32'(addr_ack), 32'(exp));
  endtask

  task automatic stop_ev();
    @(negedge clk);
    ev_stop = 1'b1;
    @(posedge clk); #1;
    ev_stop = 1'b0;
  endtask

  task automatic send_byte(input string tag, input logic [7:0] d, input logic exp_ack,
                           input logic [31:0] exp_addr);
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    chk({tag, " rx_ready"}, 32'(rx_ready), 32'd1);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (exp_ack) begin
      chk({tag, " mem_valid"}, 32'(mem_valid), 32'd1);
      chk({tag, " mem_addr"}, mem_addr, exp_addr);
      chk({tag, " mem_data"}, 32'(mem_data), 32'(d));
      @(posedge clk); #1;
      chk({tag, " resp"}, {30'd0, rx_resp_valid, rx_resp_ack}, 32'd3);
      chk({tag, " stored"}, 32'(mem_img[exp_addr[5:0]]), 32'(d));
    end else begin
      chk({tag, " nack resp"}, {30'd0, rx_resp_valid, rx_resp_ack}, 32'd2);
      chk({tag, " no mem_valid"}, 32'(mem_valid), 32'd0);
      @(posedge clk); #1;
      chk({tag, " no write"}, 32'(wr_cnt - w0), 32'd0);
    end
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mem_valid", 32'(mem_valid), 32'd0);
    chk("R1 resp", 32'(rx_resp_valid), 32'd0);
    chk("R1 rx_ready", 32'(rx_ready), 32'd1);
    chk_reg("R1 func", 8'h00, 32'h0);
    chk_reg("R1 ien", 8'h20, 32'h0);
    chk_reg("R1 ists", 8'h24, 32'h0);
    chk_reg("R1 cmd", 8'h28, 32'h0);
    chk_reg("R1 len", 8'h2c, 32'h0);
    chk_reg("R1 ptr", 8'h34, 32'h0);
    chk_reg("R1 cnt", 8'h3c, 32'h0);
  endtask

  task automatic t_config();
    reg_write(8'h00, 32'hffff_ffff);
    chk_reg("R2 func keeps 22:0", 8'h00, 32'h007f_ffff);
    reg_write(8'h00, 32'h0);
    reg_write(8'h38, 32'h2a);
    chk_reg("R2 own", 8'h38, 32'h2a);
    reg_write(8'h20, 32'h5);
    chk_reg("R2 ien", 8'h20, 32'h5);
    reg_write(8'h28, 32'h0000_abcd);
    chk_reg("R2 cmd", 8'h28, 32'h0000_abcd);
    reg_write(8'h30, 32'h1000);
    chk_reg("R11 rxbuf shares ptr", 8'h34, 32'h1000);
    chk_reg("R11 txbuf reads ptr", 8'h30, 32'h1000);
    chk_reg("R11 opaddr", 8'h40, 32'h1000);
    reg_write(8'h2c, 32'h3);
    chk_reg("R11 oplen", 8'h44, 32'h3);
  endtask

  task automatic t_match();
    start_ev("R3 disabled no ack", 7'h2a, 1'b0, 1'b0);
    reg_write(8'h00, 32'h2);
    start_ev("R3 wrong addr no ack", 7'h2b, 1'b0, 1'b0);
    start_ev("R3 read dir no ack", 7'h2a, 1'b1, 1'b0);
    start_ev("R3 match ack", 7'h2a, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R3 ack one cycle", 32'(addr_ack), 32'd0);
  endtask

  task automatic t_bytes();
    send_byte("R4 b0", 8'h11, 1'b1, 32'h1000);
    send_byte("R4 b1", 8'h22, 1'b1, 32'h1001);
    send_byte("R4 b2", 8'h33, 1'b1, 32'h1002);
    chk_reg("R4 ptr", 8'h40, 32'h1003);
    chk_reg("R4 len", 8'h44, 32'h0);
    chk_reg("R4 cnt", 8'h3c, 32'h0003_0000);
    send_byte("R6 len zero", 8'h99, 1'b0, 32'h0);
    chk_reg("R6 ptr unchanged", 8'h40, 32'h1003);
    chk_reg("R6 cnt unchanged", 8'h3c, 32'h0003_0000);
  endtask

  task automatic t_ro_views();
    reg_write(8'h40, 32'h5555);
    reg_write(8'h44, 32'h7);
    chk_reg("R11 opaddr write ignored", 8'h40, 32'h1003);
    chk_reg("R11 oplen write ignored", 8'h44, 32'h0);
  endtask

  task automatic t_stop_irq();
    stop_ev();
    chk("R7 irq", 32'(irq), 32'd1);
    chk_reg("R7 status", 8'h24, 32'h0001_0094);
    reg_write(8'h24, 32'h4);
    chk_reg("R8 partial clear", 8'h24, 32'h0001_0090);
    chk("R9 irq stays", 32'(irq), 32'd1);
    reg_write(8'h24, 32'h0001_0000);
    chk_reg("R8 widened clear", 8'h24, 32'h0);
    chk("R9 irq drops", 32'(irq), 32'd0);
  endtask

  task automatic t_backpressure();
    int w0;
    start_ev("R3 second match", 7'h2a, 1'b0, 1'b1);
    chk_reg("R3 count zeroed", 8'h3c, 32'h0);
    reg_write(8'h2c, 32'h2);
    mem_ready = 1'b0;
    w0 = wr_cnt;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h44;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    chk("R5 mem_valid", 32'(mem_valid), 32'd1);
    chk("R5 rx_ready low", 32'(rx_ready), 32'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R5 held valid", 32'(mem_valid), 32'd1);
    chk("R5 held addr", mem_addr, 32'h1003);
    chk("R5 held data", 32'(mem_data), 32'h44);
    chk("R5 no early write", 32'(wr_cnt - w0), 32'd0);
    @(negedge clk);
    mem_ready = 1'b1;
    @(posedge clk); #1;
    chk("R5 resp ack", {30'd0, rx_resp_valid, rx_resp_ack}, 32'd3);
    chk("R5 stored", 32'(mem_img[6'h03]), 32'h44);
    chk_reg("R4 cnt one", 8'h3c, 32'h0001_0000);
    chk_reg("R4 len one", 8'h44, 32'h1);
    reg_write(8'h3c, 32'h1234_5678);
    chk_reg("R10 cnt cleared", 8'h3c, 32'h0);
    stop_ev();
    chk("R7 irq second", 32'(irq), 32'd1);
    send_byte("R6 no session", 8'h55, 1'b0, 32'h0);
    chk_reg("R6 len kept", 8'h44, 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_config();
    t_match();
    t_bytes();
    t_ro_views();
    t_stop_irq();
    t_backpressure();
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule